// File: doc/BRIEF.md
# LMS Error Combining Head Node

This block sits at the head of a cascaded least-mean-square adaptive filter whose taps are split across several slices. For each sample period it accepts one primary input sample and one desired-response sample, hands the primary sample to its own local slice, and then waits for a partial dot product from the local slice and from each of a parameterised number of downstream slices. The partials can arrive in any order.

Once the last partial has arrived, the block adds them all to form the filter output. It subtracts that output from the desired response to get the error. It then scales the error by the adaptation step size, so that every slice receives a value it can use directly in its coefficient update. The scaled error goes to all slices at once, and the filter output goes out on its own stream in the same cycle. All interfaces are valid/ready streams. The step size is a Q0.16 value that can be changed only between samples.

Top module: `lms_head_node`

## Requirements
- R1: After reset, in_ready is 1, loc_x_valid, part_ready, err_valid and y_valid are all 0, and the step size is 655 (0.01 in Q0.16).
- R2: When a sample is accepted (in_valid and in_ready high at an edge), loc_x_valid rises on the next cycle with loc_x equal to the accepted in_x. Both are held until loc_x_ready is seen.
- R3: Partial sums are accepted only after the local slice has taken the sample. Bit i of part_valid/part_ready and bits [i*DW +: DW] of part_data belong to slice i, and slice 0 is the local slice. Slices can deliver in any order. Once slice i's partial is captured, part_ready[i] stays low until the sample finishes.
- R4: y_out is the sum of all captured partials, treated as signed two's complement, saturated to the DW-bit range.
- R5: The error is in_d minus y_out, saturated to the DW-bit signed range.
- R6: err_data is floor(error × mu / 65536), with mu unsigned. It is offered on every bit of err_valid together with y_valid. Each err_valid bit and y_valid stay high, with the data stable, until their own ready is seen.
- R7: y_valid and err_valid stay low until the partial from every slice has been captured. They rise in the cycle after the last capture.
- R8: A step-size write (mu_wr with mu_wdata) takes effect only when in_ready is 1. Otherwise it is ignored.
- R9: in_ready stays low from sample acceptance until every err_valid bit and y_valid have been accepted. It returns high in the following cycle, with all capture flags cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Node is idle and accepts a sample |
| in_x | input | DW | Primary input sample, signed |
| in_d | input | DW | Desired response, signed |
| loc_x_valid | output | 1 | Sample offered to local slice |
| loc_x_ready | input | 1 | Local slice takes the sample |
| loc_x | output | DW | Sample for local slice |
| part_valid | input | NSLICE+1 | Partial sum offered, per slice |
| part_ready | output | NSLICE+1 | Partial sum accepted, per slice |
| part_data | input | (NSLICE+1)*DW | Packed signed partial sums |
| err_valid | output | NSLICE+1 | Scaled error offered, per slice |
| err_ready | input | NSLICE+1 | Slice takes the scaled error |
| err_data | output | DW | Scaled error, signed, shared by all slices |
| y_valid | output | 1 | Filter output offered |
| y_ready | input | 1 | Filter output taken |
| y_out | output | DW | Filter output, signed |
| mu_wr | input | 1 | Step-size write strobe |
| mu_wdata | input | MUW | New step size, Q0.16 |

## Verification
A corrupted capture register or a wrong capture flag shows up in y_out and err_data as soon as the sample's results are offered, one cycle after the last partial arrives. The bench compares those values against an integer model for every sample. A flag that fails to clear, or a stuck sent bit, either blocks in_ready or makes an err_valid bit linger. Both are visible within one cycle of the final handshake. A step-size register that changed when it should not have is caught on the very next sample, because that sample's scaled error then differs from the model.

// File: rtl/lms_head_node.sv
module lms_head_node #(
  parameter int DW      = 16,
  parameter int NSLICE  = 3,
  parameter int MUW     = 16,
  parameter int MU_INIT = 655
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [DW-1:0]              in_x,
  input  logic [DW-1:0]              in_d,
  output logic                       loc_x_valid,
  input  logic                       loc_x_ready,
  output logic [DW-1:0]              loc_x,
  input  logic [NSLICE:0]            part_valid,
  output logic [NSLICE:0]            part_ready,
  input  logic [(NSLICE+1)*DW-1:0]   part_data,
  output logic [NSLICE:0]            err_valid,
  input  logic [NSLICE:0]            err_ready,
  output logic [DW-1:0]              err_data,
  output logic                       y_valid,
  input  logic                       y_ready,
  output logic [DW-1:0]              y_out,
  input  logic                       mu_wr,
  input  logic [MUW-1:0]             mu_wdata
);
  localparam int NP = NSLICE + 1;
  localparam int SW = DW + $clog2(NP) + 2;
  localparam int PW = DW + MUW + 1;
  localparam logic signed [SW-1:0] MAXV = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = ~MAXV;

  typedef enum logic [1:0] {S_IDLE, S_FEED, S_GATHER, S_SEND} st_t;

  st_t             st;
  logic [DW-1:0]   x_q, d_q, y_q, err_q;
  logic [MUW-1:0]  mu_q;
  logic [NP-1:0]   got, sent;
  logic            y_done;
  logic [DW-1:0]   cap [NP];

  logic [NP-1:0]          part_fire;
  logic                   all_in, done;
  logic signed [SW-1:0]   acc, e_full;
  logic [DW-1:0]          ysat, esat, scaled;
  logic signed [PW-1:0]   prod;

  function automatic logic [DW-1:0] sat(input logic signed [SW-1:0] v);
    if (v > MAXV)      return MAXV[DW-1:0];
    else if (v < MINV) return MINV[DW-1:0];
    else               return v[DW-1:0];
  endfunction

  assign in_ready    = (st == S_IDLE);
  assign loc_x_valid = (st == S_FEED);
  assign loc_x       = x_q;
  assign part_ready  = (st == S_GATHER) ? ~got : '0;
  assign part_fire   = part_valid & part_ready;
  assign all_in      = (st == S_GATHER) && (&(got | part_fire));
  assign err_valid   = (st == S_SEND) ? ~sent : '0;
  assign err_data    = err_q;
  assign y_valid     = (st == S_SEND) && !y_done;
  assign y_out       = y_q;
  assign done        = (st == S_SEND) && (&(sent | (err_valid & err_ready)))
                       && (y_done || y_ready);

  always_comb begin
    acc = '0;
    for (int i = 0; i < NP; i++) begin
      logic [DW-1:0] v;
      v   = part_fire[i] ? part_data[i*DW +: DW] : cap[i];
      acc = acc + {{(SW-DW){v[DW-1]}}, v};
    end
  end

  assign ysat   = sat(acc);
  assign e_full = {{(SW-DW){d_q[DW-1]}}, d_q} - {{(SW-DW){ysat[DW-1]}}, ysat};
  assign esat   = sat(e_full);
  assign prod   = $signed({{(MUW+1){esat[DW-1]}}, esat}) * $signed({{(DW+1){1'b0}}, mu_q});
  assign scaled = prod[MUW +: DW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      x_q    <= '0;
      d_q    <= '0;
      y_q    <= '0;
      err_q  <= '0;
      mu_q   <= MUW'(MU_INIT);
      got    <= '0;
      sent   <= '0;
      y_done <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (mu_wr) mu_q <= mu_wdata;
          if (in_valid) begin
            x_q <= in_x;
            d_q <= in_d;
            st  <= S_FEED;
          end
        end
        S_FEED:   if (loc_x_ready) st <= S_GATHER;
        S_GATHER: begin
          got <= got | part_fire;
          if (all_in) begin
            y_q   <= ysat;
            err_q <= scaled;
            st    <= S_SEND;
          end
        end
        S_SEND: begin
          if (done) begin
            got    <= '0;
            sent   <= '0;
            y_done <= 1'b0;
            st     <= S_IDLE;
          end else begin
            sent <= sent | (err_valid & err_ready);
            if (y_ready) y_done <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NP; g++) begin : g_cap
    always_ff @(posedge clk) begin
      if (!rst_n)            cap[g] <= '0;
      else if (part_fire[g]) cap[g] <= part_data[g*DW +: DW];
    end

    assert_capture_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
      part_fire[g] |=> !part_ready[g]);

    assert_err_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (err_valid[g] && !err_ready[g]) |=> (err_valid[g] && $stable(err_data)));
  end

  assert_x_handoff_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (loc_x_valid && loc_x == $past(in_x)));

  assert_y_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (y_valid && !y_ready) |=> (y_valid && $stable(y_out)));

  assert_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(y_valid) |-> $past(|part_fire));

  assert_mu_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mu_wr && !in_ready) |=> $stable(mu_q));

endmodule

// File: tb/lms_head_node_bench.sv
module lms_head_node_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int NS = 3;
  localparam int NP = NS + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, loc_x_ready = 1'b0, y_ready = 1'b0, mu_wr = 1'b0;
  logic [DW-1:0] in_x = '0, in_d = '0;
  logic [15:0] mu_wdata = '0;
  logic [NP-1:0] part_valid = '0, err_ready = '0;
  logic [NP*DW-1:0] part_data = '0;
  logic in_ready, loc_x_valid, y_valid;
  logic [DW-1:0] loc_x, err_data, y_out;
  logic [NP-1:0] part_ready, err_valid;

  int total = 0, bad = 0, cycles = 0;
  int mu_m = 655;

  lms_head_node #(.DW(DW), .NSLICE(NS), .MUW(16), .MU_INIT(655)) u_lms_head_node (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_d(in_d), .loc_x_valid(loc_x_valid), .loc_x_ready(loc_x_ready),
    .loc_x(loc_x), .part_valid(part_valid), .part_ready(part_ready),
    .part_data(part_data), .err_valid(err_valid), .err_ready(err_ready),
    .err_data(err_data), .y_valid(y_valid), .y_ready(y_ready), .y_out(y_out),
    .mu_wr(mu_wr), .mu_wdata(mu_wdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-clock protocol model: pending offers must persist unchanged
  logic [NP-1:0] pend_e = '0;
  logic pend_y = 1'b0;
  logic [DW-1:0] last_e, last_y;
  always @(posedge clk) begin
    cycles++;
    if (rst_n) begin
      for (int i = 0; i < NP; i++)
        if (pend_e[i]) check(err_valid[i] && err_data == last_e, "R6 err hold", err_valid[i], 1);
      if (pend_y) check(y_valid && y_out == last_y, "R6 y hold", y_valid, 1);
      pend_e = err_valid & ~err_ready;
      pend_y = y_valid & ~y_ready;
      last_e = err_data;
      last_y = y_out;
    end
  end

  function automatic longint satv(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_mu(input int v);
    mu_wr = 1'b1; mu_wdata = v[15:0];
    step();
    mu_wr = 1'b0;
    mu_m = v;
  endtask

  task automatic run(input int x, input int d, input int p[NP], input int ord[NP]);
    longint ys, y, e, s;
    ys = 0;
    for (int i = 0; i < NP; i++) ys += p[i];
    y = satv(ys);
    e = satv(d - y);
    s = (e * mu_m) >>> 16;
    check(in_ready == 1'b1, "R9 idle before sample", in_ready, 1);
    in_valid = 1'b1; in_x = x[DW-1:0]; in_d = d[DW-1:0];
    step();
    in_valid = 1'b0;
    check(loc_x_valid && loc_x == x[DW-1:0], "R2 x to local", loc_x, x[DW-1:0]);
    check(in_ready == 1'b0, "R9 busy", in_ready, 0);
    step();
    check(loc_x_valid && loc_x == x[DW-1:0], "R2 x held", loc_x_valid, 1);
    check(part_ready == '0, "R3 no partial before handoff", part_ready, 0);
    loc_x_ready = 1'b1;
    step();
    loc_x_ready = 1'b0;
    check(loc_x_valid == 1'b0, "R2 x released", loc_x_valid, 0);
    for (int k = 0; k < NP; k++) begin
      int idx;
      idx = ord[k];
      check(!y_valid && err_valid == '0, "R7 no result early", y_valid, 0);
      check(part_ready[idx] == 1'b1, "R3 slot open", part_ready[idx], 1);
      part_valid[idx] = 1'b1;
      part_data[idx*DW +: DW] = p[idx][DW-1:0];
      step();
      part_valid[idx] = 1'b0;
      if (k < NP-1) check(part_ready[idx] == 1'b0, "R3 slot closed", part_ready[idx], 0);
    end
    check(y_valid == 1'b1, "R7 y after last", y_valid, 1);
    check($signed(y_out) == y, "R4 y value", $signed(y_out), y);
    check(err_valid == {NP{1'b1}}, "R6 broadcast", err_valid, 15);
    check($signed(err_data) == s, "R5 R6 scaled error", $signed(err_data), s);
    mu_wr = 1'b1; mu_wdata = 16'h1234;
    step();
    mu_wr = 1'b0;
    check(in_ready == 1'b0, "R9 busy while sending", in_ready, 0);
    err_ready = 4'b0101;
    step();
    err_ready = '0;
    check(err_valid == 4'b1010 && y_valid, "R6 partial accept", err_valid, 10);
    err_ready = 4'b1010; y_ready = 1'b1;
    step();
    err_ready = '0; y_ready = 1'b0;
    check(err_valid == '0 && !y_valid, "R6 all taken", err_valid, 0);
    check(in_ready == 1'b1, "R9 idle again", in_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    check(!loc_x_valid && !y_valid && err_valid == '0 && part_ready == '0,
          "R1 outputs idle", err_valid, 0);
    // R1 default step size, R8 busy write ignored (verified by next sample)
    run(100, 1000, '{10, 20, 30, 40}, '{0, 1, 2, 3});
    run(-300, 500, '{-7, 123, 4000, -2}, '{3, 2, 1, 0});
    run(1234, -2000, '{500, -600, 700, 800}, '{2, 0, 3, 1});
    write_mu(65535);   // R8 idle write takes effect
    run(0, 32767, '{-32768, 0, 0, 0}, '{1, 3, 0, 2});
    run(5, -32768, '{32767, 32767, 32767, 32767}, '{0, 2, 1, 3});
    write_mu(32768);
    run(77, 100, '{1, -1, 2, -2}, '{3, 0, 2, 1});
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles >= 5000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule